// File: doc/BRIEF.md
# PCI Initiator Bus Ownership Controller

This block handles bus tenure for the initiator side of a PCI agent. When local logic has data to move, the block pulls its dedicated active-low request line low towards the system arbiter. It watches its own grant line and the shared FRAME# and IRDY# lines. On the first clock edge where the grant is present and the bus is idle, it takes the bus and starts the address phase in the very next cycle. From then on it sequences FRAME# and IRDY# through address, data, last-data and turnaround cycles.

While the grant is held, ownership continues until the local side finishes or the target signals a disconnect on STOP#. If the arbiter withdraws the grant, a programmable 8-bit tenure counter still guarantees a minimum ownership window. Only when the counter has run out does the block begin an orderly wind-down: FRAME# goes high first, and IRDY# is released after the final data phase. Separate drive enables stay active for one extra turnaround clock, so that another master can take over without contention.

Top module: `pci_own_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_n`, `frame_out_n` and `irdy_out_n` are 1, and `frame_oe`, `irdy_oe` and `owner` are 0.
- R2: While idle and not cooling down, `req_n` goes low one clock after an edge where `xfer_req` is sampled high, and it stays low while the block holds the bus in the address or data phase and `xfer_req` stays high.
- R3: Ownership is taken only on an edge where `req_n` is low, `gnt_n` is low, `frame_in_n` is 1 and `irdy_in_n` is 1. Right after that edge `owner`, `frame_oe` and `irdy_oe` are 1 and `frame_out_n` is 0. A busy bus or a missing grant never starts a tenure.
- R4: The address phase lasts exactly one clock. `irdy_out_n` goes low one clock after `frame_out_n` first goes low, and FRAME# stays low.
- R5: On the take edge, an 8-bit tenure counter loads `lat_val`. It then decrements once per clock and saturates at 0. A deasserted `gnt_n` has no effect on the data phase while the counter is non-zero.
- R6: On an edge in the data phase where any of these holds — `xfer_req` low, `stop_n` low, or `gnt_n` high with the counter at 0 — `frame_out_n` goes to 1 while `irdy_out_n` stays 0 (last data phase).
- R7: In the last data phase, `irdy_out_n` stays 0 until an edge where `trdy_n` or `stop_n` is sampled low. After that edge it goes to 1.
- R8: After IRDY# is released, `frame_oe`, `irdy_oe` and `owner` stay 1 for exactly one clock with both bus outputs at 1, then all three drop to 0.
- R9: `req_n` is 1 from the clock FRAME# is released until at least one clock after `owner` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | 1 | Local side wants to transfer or continue |
| gnt_n | input | 1 | Dedicated grant from arbiter, active low |
| frame_in_n | input | 1 | Sampled shared FRAME# |
| irdy_in_n | input | 1 | Sampled shared IRDY# |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop/disconnect, active low |
| lat_val | input | 8 | Minimum tenure in clocks |
| req_n | output | 1 | Request to arbiter, active low |
| frame_out_n | output | 1 | FRAME# value to drive |
| frame_oe | output | 1 | FRAME# drive enable |
| irdy_out_n | output | 1 | IRDY# value to drive |
| irdy_oe | output | 1 | IRDY# drive enable |
| owner | output | 1 | Block currently holds the bus |

## Verification
The hardest case to reach is a grant withdrawn in mid-tenure while the tenure counter still runs. The wind-down must then start on exactly the edge where the counter reaches zero, not earlier, with no disconnect and no local stop. A directed sequence sets the counter to six, drops the grant just after the take edge, and holds the target ready with STOP# inactive. It then checks every clock through release, turnaround and the REQ# gap. Random traffic follows, with grant, bus-busy, TRDY#, STOP# and tenure values drawn from a seeded generator and compared against a cycle model in the bench.

// File: rtl/pci_own_pkg.sv
package pci_own_pkg;

    localparam int LAT_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_LAST = 3'd3,
        ST_TURN = 3'd4
    } own_st_e;

    typedef struct packed {
        logic frame_n;
        logic irdy_n;
        logic oe;
    } bus_drv_t;

    // Output drive pattern that belongs to each tenure state
    function automatic bus_drv_t drv_for(own_st_e s);
        bus_drv_t d;
        d.frame_n = !(s == ST_ADDR || s == ST_DATA);
        d.irdy_n  = !(s == ST_DATA || s == ST_LAST);
        d.oe      = (s != ST_IDLE);
        return d;
    endfunction

    function automatic logic may_request(own_st_e s);
        return (s == ST_IDLE || s == ST_ADDR || s == ST_DATA);
    endfunction

endpackage

// File: rtl/lat_timer.sv
module lat_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(val)));

    p_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == W'($past(cnt) - 1'b1)));

endmodule

// File: rtl/req_gen.sv
module req_gen
    import pci_own_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    xfer_req,
    input  own_st_e st,
    input  own_st_e nxt,
    input  logic    owner,
    output logic    req_n
);
    logic want;

    // No request in the turnaround clock nor in the clock that follows it
    assign want = xfer_req && may_request(nxt) && (st != ST_TURN);

    always_ff @(posedge clk) begin
        if (rst) req_n <= 1'b1;
        else     req_n <= !want;
    end

    p_req_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(owner) |-> req_n);

endmodule

// File: rtl/own_fsm.sv
module own_fsm
    import pci_own_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_n,
    input  logic     gnt_n,
    input  logic     frame_in_n,
    input  logic     irdy_in_n,
    input  logic     trdy_n,
    input  logic     stop_n,
    input  logic     xfer_req,
    input  logic     expired,
    output own_st_e  st,
    output own_st_e  nxt,
    output logic     take,
    output bus_drv_t drv
);
    logic bus_idle;
    logic finish;
    logic phase_end;

    assign bus_idle  = frame_in_n && irdy_in_n;
    assign take      = (st == ST_IDLE) && !req_n && !gnt_n && bus_idle;
    assign finish    = !xfer_req || !stop_n || (gnt_n && expired);
    assign phase_end = !trdy_n || !stop_n;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (take)      nxt = ST_ADDR;
            ST_ADDR:                nxt = ST_DATA;
            ST_DATA: if (finish)    nxt = ST_LAST;
            ST_LAST: if (phase_end) nxt = ST_TURN;
            ST_TURN:                nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            drv <= drv_for(ST_IDLE);
        end else begin
            st  <= nxt;
            drv <= drv_for(nxt);
        end
    end

    p_take_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.oe) |-> $past(!gnt_n && frame_in_n && irdy_in_n && !req_n));

    p_addr_then_irdy_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.frame_n) |=> (!drv.irdy_n && !drv.frame_n));

    p_timer_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && !expired && xfer_req && stop_n) |=> !drv.frame_n);

    p_irdy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LAST && trdy_n && stop_n) |=> !drv.irdy_n);

    p_turn_r8: assert property (@(posedge clk) disable iff (rst)
        (drv.oe && drv.frame_n && drv.irdy_n) |=> !drv.oe);

endmodule

// File: rtl/pci_own_ctl.sv
module pci_own_ctl
    import pci_own_pkg::*;
#(
    parameter int TW = LAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_req,
    input  logic          gnt_n,
    input  logic          frame_in_n,
    input  logic          irdy_in_n,
    input  logic          trdy_n,
    input  logic          stop_n,
    input  logic [TW-1:0] lat_val,
    output logic          req_n,
    output logic          frame_out_n,
    output logic          frame_oe,
    output logic          irdy_out_n,
    output logic          irdy_oe,
    output logic          owner
);
    own_st_e  st, nxt;
    logic     take;
    logic     expired;
    bus_drv_t drv;

    own_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_n      (req_n),
        .gnt_n      (gnt_n),
        .frame_in_n (frame_in_n),
        .irdy_in_n  (irdy_in_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n),
        .xfer_req   (xfer_req),
        .expired    (expired),
        .st         (st),
        .nxt        (nxt),
        .take       (take),
        .drv        (drv)
    );

    lat_timer #(.W(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (take),
        .val     (lat_val),
        .expired (expired)
    );

    req_gen u_req (
        .clk      (clk),
        .rst      (rst),
        .xfer_req (xfer_req),
        .st       (st),
        .nxt      (nxt),
        .owner    (drv.oe),
        .req_n    (req_n)
    );

    assign frame_out_n = drv.frame_n;
    assign irdy_out_n  = drv.irdy_n;
    assign frame_oe    = drv.oe;
    assign irdy_oe     = drv.oe;
    assign owner       = drv.oe;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (req_n && frame_out_n && irdy_out_n && !owner));

    p_frame_only_when_owner_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_out_n |-> frame_oe);

endmodule

// File: tb/sim_pci_own_ctl.sv
`timescale 1ns/1ps
module sim_pci_own_ctl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_req = 1'b0, gnt_n = 1'b1, oth_f = 1'b1, oth_i = 1'b1;
    logic trdy_n = 1'b1, stop_n = 1'b1;
    logic [7:0] lat_val = 8'd0;
    logic req_n, frame_out_n, frame_oe, irdy_out_n, irdy_oe, owner;
    logic frame_in_n, irdy_in_n;

    int n_chk = 0, n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // shared bus lines: our drive when enabled, otherwise the other master
    assign frame_in_n = frame_oe ? frame_out_n : oth_f;
    assign irdy_in_n  = irdy_oe  ? irdy_out_n  : oth_i;

    pci_own_ctl u0 (
        .clk(clk), .rst(rst), .xfer_req(xfer_req), .gnt_n(gnt_n),
        .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .lat_val(lat_val), .req_n(req_n),
        .frame_out_n(frame_out_n), .frame_oe(frame_oe),
        .irdy_out_n(irdy_out_n), .irdy_oe(irdy_oe), .owner(owner)
    );

    // Cycle model built from the requirements: 0 idle,1 addr,2 data,3 last,4 turn
    int m_st = 0, m_nx;
    int m_cnt = 0;
    logic m_req = 1'b1;

    function automatic logic e_frame(int s); return !(s == 1 || s == 2); endfunction
    function automatic logic e_irdy(int s);  return !(s == 2 || s == 3); endfunction
    function automatic logic e_oe(int s);    return s != 0; endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0; m_cnt <= 0; m_req <= 1'b1;
        end else begin
            m_nx = m_st;
            case (m_st)
                0: if (!m_req && !gnt_n && frame_in_n && irdy_in_n) m_nx = 1;
                1: m_nx = 2;
                2: if (!xfer_req || !stop_n || (gnt_n && m_cnt == 0)) m_nx = 3;
                3: if (!trdy_n || !stop_n) m_nx = 4;
                default: m_nx = 0;
            endcase
            if (m_st == 0 && m_nx == 1) m_cnt <= lat_val;
            else if (m_cnt > 0) m_cnt <= m_cnt - 1;
            m_req <= !(xfer_req && m_nx <= 2 && m_st != 4);
            m_st <= m_nx;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk("R2 req_n model", req_n, m_req);
            chk("R3 frame_out_n model", frame_out_n, e_frame(m_st));
            chk("R7 irdy_out_n model", irdy_out_n, e_irdy(m_st));
            chk("R8 frame_oe model", frame_oe, e_oe(m_st));
            chk("R8 irdy_oe model", irdy_oe, e_oe(m_st));
            chk("R3 owner model", owner, e_oe(m_st));
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req_n", req_n, 1'b1);
        chk("R1 frame_out_n", frame_out_n, 1'b1);
        chk("R1 irdy_out_n", irdy_out_n, 1'b1);
        chk("R1 frame_oe", frame_oe, 1'b0);
        chk("R1 irdy_oe", irdy_oe, 1'b0);
        chk("R1 owner", owner, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 owner after release", owner, 1'b0);
        cmp_en = 1'b1;

        // Directed: grant withdrawn early, tenure counter = 6
        xfer_req = 1'b1; gnt_n = 1'b0; trdy_n = 1'b0; stop_n = 1'b1; lat_val = 8'd6;
        @(negedge clk);
        chk("R2 req low", req_n, 1'b0);
        chk("R2 not yet owner", owner, 1'b0);
        @(negedge clk);
        chk("R3 frame after take", frame_out_n, 1'b0);
        chk("R3 owner after take", owner, 1'b1);
        chk("R3 irdy still high", irdy_out_n, 1'b1);
        gnt_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R5 frame held by counter", frame_out_n, 1'b0);
            if (k == 1) chk("R4 irdy after addr", irdy_out_n, 1'b0);
        end
        @(negedge clk);
        chk("R6 frame released", frame_out_n, 1'b1);
        chk("R6 irdy held", irdy_out_n, 1'b0);
        chk("R9 req high at release", req_n, 1'b1);
        @(negedge clk);
        chk("R7 irdy released", irdy_out_n, 1'b1);
        chk("R8 enable held", irdy_oe, 1'b1);
        @(negedge clk);
        chk("R8 enable dropped", frame_oe, 1'b0);
        chk("R8 owner dropped", owner, 1'b0);
        chk("R9 req gap", req_n, 1'b1);
        @(negedge clk);
        chk("R9 req again", req_n, 1'b0);

        // Directed: target disconnect
        gnt_n = 1'b0; lat_val = 8'd0; trdy_n = 1'b1;
        @(negedge clk);
        chk("R3 owner on idle grant", owner, 1'b1);
        @(negedge clk);
        stop_n = 1'b0;
        @(negedge clk);
        chk("R6 stop frees frame", frame_out_n, 1'b1);
        chk("R6 stop irdy held", irdy_out_n, 1'b0);
        @(negedge clk);
        chk("R7 stop ends phase", irdy_out_n, 1'b1);
        stop_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed: busy bus with grant never starts a tenure
        oth_f = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk("R3 busy bus no take", owner, 1'b0);
        end
        oth_f = 1'b1;

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if ($urandom_range(9) == 0) xfer_req = ~xfer_req;
            gnt_n   = ($urandom_range(9) < 3);
            oth_f   = ($urandom_range(9) < 8);
            oth_i   = ($urandom_range(9) < 8);
            trdy_n  = ($urandom_range(9) < 4);
            stop_n  = ($urandom_range(19) != 0);
            lat_val = 8'($urandom_range(15));
        end
        @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule